// File: doc/BRIEF.md
# LIN host header generator

This block produces the header part of a LIN frame on a single serial output. A start command begins the sequence. The block drives a dominant (low) break of programmable length, then a recessive (high) gap, then the sync byte. A second recessive gap follows, and then the protected identifier byte. The identifier byte holds the 6-bit frame ID and two parity bits, and the block computes those bits itself.

Every bit time is marked by a one-clock tick from an external baud generator. The block changes the line only on the clock edge that consumes a tick, or on the edge that accepts a start command. The frame ID and both select codes are captured when a start command is accepted, so the caller may change them while a header is in flight. Response data, checksum and break detection on the receiving side belong to other blocks.

Top module: `lin_hdr_gen`

## Requirements
- R1: After reset, and while no header is in progress, the line is high, busy is low and done is low. A reset in the middle of a header returns the block to this state.
- R2: The break is a run of low bit times whose length depends on the break select: code 0 gives 13, code 1 gives 17, code 2 gives 21 and code 3 gives 26.
- R3: The high gap between the break and the sync byte depends on the delay select: code 0 gives 1 bit time, code 1 gives 4, code 2 gives 8 and code 3 gives 14.
- R4: The high gap between the sync byte and the identifier byte is 1 bit time for delay code 0 and 4 bit times for codes 1, 2 and 3.
- R5: The sync field is a 10-bit frame: a low start bit, then the byte 0x55 least significant bit first, then a high stop bit.
- R6: The identifier field is a 10-bit frame: a low start bit, then the byte {P1, P0, ID[5:0]} least significant bit first, then a high stop bit, where P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5).
- R7: A start command seen while busy is low is accepted, and in the next cycle busy is high and the line is low. A start command seen while busy is high has no effect on the header being sent.
- R8: Done is high for exactly one clock, in the cycle after the tick that ends the stop bit of the identifier field. Busy falls in that same cycle and at no other time except reset.
- R9: While a header is in progress, the line changes only in the cycle after a bit tick.
- R10: The frame ID, break select and delay select are sampled when a start command is accepted. Changes to them during the header have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-header command |
| frame_id_i | input | 6 | Frame ID to place in the identifier byte |
| brk_sel_i | input | 2 | Break length select |
| dly_sel_i | input | 2 | Inter-field gap select |
| bit_tick_i | input | 1 | One-clock pulse marking the end of each bit time |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | High while a header is being sent |
| done_o | output | 1 | One-clock pulse when the header is complete |

## Verification
The bench runs through every break code and every delay code. Among these runs, delay code 0 is the only setting that shortens the second gap, and a design that indexed that gap with the first gap's table would send a sync-to-ID gap of 8 or 14 bits. It checks the parity on IDs of all zeros, all ones and mixed values, because a swapped or uninverted P1 shows up as a wrong identifier byte. The sync stop bit and the gap after it are both high, so a design whose sync field is one bit short or long gives a gap length that is off by one. The bench also drives a second start command and changes the captured inputs in the middle of a header, and resets the block halfway through. A design that re-latched its inputs or restarted would send a different bit stream, or a second done pulse.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    // Bits per serial character: start, eight data, stop.
    localparam int FRAME_BITS = 10;
    localparam logic [7:0] SYNC_BYTE = 8'h55;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_BRK  = 3'd1,
        S_GAP1 = 3'd2,
        S_SYNC = 3'd3,
        S_GAP2 = 3'd4,
        S_ID   = 3'd5
    } hdr_state_e;

endpackage

// File: rtl/lin_gap_table.sv
// Maps the break and delay select codes to lengths in bit times.
module lin_gap_table #(
    parameter int CNT_W = 5
) (
    input  logic [1:0]       brk_sel_i,
    input  logic [1:0]       dly_sel_i,
    output logic [CNT_W-1:0] brk_len_o,
    output logic [CNT_W-1:0] gap1_len_o,
    output logic [CNT_W-1:0] gap2_len_o
);
    always_comb begin
        case (brk_sel_i)
            2'd0:    brk_len_o = CNT_W'(13);
            2'd1:    brk_len_o = CNT_W'(17);
            2'd2:    brk_len_o = CNT_W'(21);
            default: brk_len_o = CNT_W'(26);
        endcase
        case (dly_sel_i)
            2'd0:    gap1_len_o = CNT_W'(1);
            2'd1:    gap1_len_o = CNT_W'(4);
            2'd2:    gap1_len_o = CNT_W'(8);
            default: gap1_len_o = CNT_W'(14);
        endcase
        gap2_len_o = (dly_sel_i == 2'd0) ? CNT_W'(1) : CNT_W'(4);
    end
endmodule

// File: rtl/lin_pid_calc.sv
// Builds the protected identifier byte from a 6-bit frame ID.
module lin_pid_calc (
    input  logic [5:0] id_i,
    output logic [7:0] pid_o
);
    logic par0, par1;
    always_comb begin
        par0  = id_i[0] ^ id_i[1] ^ id_i[2] ^ id_i[4];
        par1  = ~(id_i[1] ^ id_i[3] ^ id_i[4] ^ id_i[5]);
        pid_o = {par1, par0, id_i};
    end
endmodule

// File: rtl/lin_hdr_gen.sv
// Transmits break, gap, sync, gap and identifier, each bit paced by bit_tick_i.
// CNT_W must hold 26 and 10.
module lin_hdr_gen
    import lin_hdr_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [5:0] frame_id_i,
    input  logic [1:0] brk_sel_i,
    input  logic [1:0] dly_sel_i,
    input  logic       bit_tick_i,
    output logic       tx_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_BITS);

    typedef struct packed {
        hdr_state_e       st;
        logic [CNT_W-1:0] cnt;   // bit times left in the current field
        logic [CNT_W-1:0] gap1;
        logic [CNT_W-1:0] gap2;
        logic [8:0]       sh;    // remaining bits of the character being sent
        logic [7:0]       pid;
        logic             tx;
        logic             done;
    } hdr_reg_t;

    localparam hdr_reg_t REG_RST = '{
        st: S_IDLE, cnt: '0, gap1: '0, gap2: '0,
        sh: '1, pid: '0, tx: 1'b1, done: 1'b0
    };

    hdr_reg_t r_d, r_q;

    logic [CNT_W-1:0] brk_len, gap1_len, gap2_len;
    logic [7:0]       pid_val;
    logic             last_tick;

    lin_gap_table #(.CNT_W(CNT_W)) u_tbl (
        .brk_sel_i  (brk_sel_i),
        .dly_sel_i  (dly_sel_i),
        .brk_len_o  (brk_len),
        .gap1_len_o (gap1_len),
        .gap2_len_o (gap2_len)
    );

    lin_pid_calc u_pid (
        .id_i  (frame_id_i),
        .pid_o (pid_val)
    );

    assign last_tick = bit_tick_i && (r_q.cnt == CNT_ONE);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                r_d.tx = 1'b1;
                if (start_i) begin
                    r_d.st   = S_BRK;
                    r_d.tx   = 1'b0;
                    r_d.cnt  = brk_len;
                    r_d.gap1 = gap1_len;
                    r_d.gap2 = gap2_len;
                    r_d.pid  = pid_val;
                end
            end
            S_BRK: begin
                if (last_tick) begin
                    r_d.st  = S_GAP1;
                    r_d.tx  = 1'b1;
                    r_d.cnt = r_q.gap1;
                end else if (bit_tick_i) begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            S_GAP1: begin
                if (last_tick) begin
                    r_d.st  = S_SYNC;
                    r_d.tx  = 1'b0;
                    r_d.sh  = {1'b1, SYNC_BYTE};
                    r_d.cnt = CNT_FRAME;
                end else if (bit_tick_i) begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            S_SYNC: begin
                if (last_tick) begin
                    r_d.st  = S_GAP2;
                    r_d.tx  = 1'b1;
                    r_d.cnt = r_q.gap2;
                end else if (bit_tick_i) begin
                    r_d.tx  = r_q.sh[0];
                    r_d.sh  = {1'b1, r_q.sh[8:1]};
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            S_GAP2: begin
                if (last_tick) begin
                    r_d.st  = S_ID;
                    r_d.tx  = 1'b0;
                    r_d.sh  = {1'b1, r_q.pid};
                    r_d.cnt = CNT_FRAME;
                end else if (bit_tick_i) begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            S_ID: begin
                if (last_tick) begin
                    r_d.st   = S_IDLE;
                    r_d.tx   = 1'b1;
                    r_d.done = 1'b1;
                end else if (bit_tick_i) begin
                    r_d.tx  = r_q.sh[0];
                    r_d.sh  = {1'b1, r_q.sh[8:1]};
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            default: r_d = REG_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REG_RST;
        else        r_q <= r_d;
    end

    assign tx_o   = r_q.tx;
    assign busy_o = (r_q.st != S_IDLE);
    assign done_o = r_q.done;
endmodule

// File: rtl/lin_hdr_chk.sv
module lin_hdr_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic bit_tick_i,
    input logic tx_o,
    input logic busy_o,
    input logic done_o
);
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);

    a_r7_start_begins_break: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !tx_o));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r8_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r9_tx_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$past(bit_tick_i)) |-> $stable(tx_o));
endmodule

bind lin_hdr_gen lin_hdr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bit_tick_i (bit_tick_i),
    .tx_o       (tx_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/sim_lin_hdr_gen.sv
`timescale 1ns/1ps
module sim_lin_hdr_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [5:0] frame_id_i = '0;
    logic [1:0] brk_sel_i = '0;
    logic [1:0] dly_sel_i = '0;
    logic       bit_tick_i = 1'b0;
    logic       tx_o, busy_o, done_o;

    always #2 clk = ~clk;

    lin_hdr_gen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_id_i(frame_id_i),
        .brk_sel_i(brk_sel_i), .dly_sel_i(dly_sel_i), .bit_tick_i(bit_tick_i),
        .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int tick_ph = 0;
    bit cap [0:127];
    int cap_len = 0;
    int done_cnt = 0;

    // {id[5:0], brk_sel[1:0], dly_sel[1:0]}
    localparam logic [9:0] VEC [8] = '{
        {6'h00, 2'd0, 2'd0}, {6'h3F, 2'd1, 2'd1}, {6'h12, 2'd2, 2'd2},
        {6'h2A, 2'd3, 2'd3}, {6'h3C, 2'd0, 2'd3}, {6'h01, 2'd3, 2'd0},
        {6'h15, 2'd2, 2'd1}, {6'h27, 2'd1, 2'd2}
    };

    // Tick every third clock; record the bit on the line at each tick.
    always @(negedge clk) begin
        cycles++;
        if (done_o) done_cnt++;
        tick_ph = (tick_ph + 1) % 3;
        bit_tick_i = (tick_ph == 0);
        if (bit_tick_i && busy_o && cap_len < 128) begin
            cap[cap_len] = tx_o;
            cap_len++;
        end
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int e_brk(input logic [1:0] b);
        case (b) 2'd0: return 13; 2'd1: return 17; 2'd2: return 21; default: return 26; endcase
    endfunction
    function automatic int e_g1(input logic [1:0] d);
        case (d) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
    endfunction
    function automatic int e_g2(input logic [1:0] d);
        return (d == 2'd0) ? 1 : 4;
    endfunction
    function automatic int e_idf(input logic [5:0] id);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return int'({1'b1, p1, p0, id, 1'b0});
    endfunction

    // Decode the captured stream and compare each field with its requirement.
    task automatic analyze(input logic [5:0] id, input logic [1:0] b, input logic [1:0] d);
        int pos = 0;
        int n;
        int v;
        n = 0; while (pos < cap_len && cap[pos] == 1'b0) begin n++; pos++; end
        chk("R2 break length", n, e_brk(b));
        n = 0; while (pos < cap_len && cap[pos] == 1'b1) begin n++; pos++; end
        chk("R3 gap after break", n, e_g1(d));
        v = 0; for (int i = 0; i < 10; i++) if (pos + i < cap_len && cap[pos + i]) v |= (1 << i);
        pos += 10;
        chk("R5 sync field", v, int'({1'b1, 8'h55, 1'b0}));
        n = 0; while (pos < cap_len && cap[pos] == 1'b1) begin n++; pos++; end
        chk("R4 gap after sync", n, e_g2(d));
        v = 0; for (int i = 0; i < 10; i++) if (pos + i < cap_len && cap[pos + i]) v |= (1 << i);
        pos += 10;
        chk("R6 identifier field", v, e_idf(id));
        chk("R6 total bit times", cap_len, e_brk(b) + e_g1(d) + e_g2(d) + 20);
    endtask

    // Send one header; scramble inputs after start (R10); optional second start at poke.
    task automatic run_hdr(input logic [5:0] id, input logic [1:0] b, input logic [1:0] d,
                           input int poke);
        int n = 0;
        @(negedge clk);
        cap_len = 0;
        done_cnt = 0;
        frame_id_i = id; brk_sel_i = b; dly_sel_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        frame_id_i = ~id; brk_sel_i = ~b; dly_sel_i = ~d;
        chk("R7 busy after start", int'(busy_o), 1);
        chk("R7 line low after start", int'(tx_o), 0);
        while (!done_o && n < 1000) begin
            @(negedge clk);
            n++;
            if (poke != 0 && n == poke) start_i = 1'b1;
            if (poke != 0 && n == poke + 1) start_i = 1'b0;
        end
        start_i = 1'b0;
        chk("R8 done seen", int'(done_o), 1);
        chk("R8 busy low with done", int'(busy_o), 0);
        @(negedge clk);
        chk("R8 done one clock", int'(done_o), 0);
        analyze(id, b, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset tx", int'(tx_o), 1);
        chk("R1 reset busy", int'(busy_o), 0);
        chk("R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle tx", int'(tx_o), 1);

        // Table walk; every entry also exercises R10 via scrambled inputs.
        for (int k = 0; k < 8; k++)
            run_hdr(VEC[k][9:4], VEC[k][3:2], VEC[k][1:0], 0);

        // R7: second start mid-header is ignored; only one done follows.
        run_hdr(6'h0B, 2'd1, 2'd2, 40);
        repeat (300) @(negedge clk);
        chk("R7 no restart busy", int'(busy_o), 0);
        chk("R7 single done", done_cnt, 1);

        // R1: reset in the middle of a header.
        @(negedge clk);
        frame_id_i = 6'h05; brk_sel_i = 2'd3; dly_sel_i = 2'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset tx", int'(tx_o), 1);
        chk("R1 mid reset busy", int'(busy_o), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 idle after mid reset", int'(tx_o), 1);

        // R9/R10 once more after reset with the longest settings.
        run_hdr(6'h3A, 2'd3, 2'd3, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule